// File: doc/BRIEF.md
# Edge-Timestamp Capture Unit with Optional Glitch Filter

This block records the moment an external signal changes. It samples an asynchronous capture pin through a synchroniser. On a transition of the chosen polarity it copies a free-running counter value, supplied from outside, into a capture register. It then raises a sticky capture flag. The flag, gated by an interrupt enable, forms an interrupt request.

An optional run-length filter can be placed in the pin path. It passes a new level only after the synchronised pin has held that level for four consecutive clocks. Short glitches are therefore rejected, at the cost of a fixed extra latency of four clocks. The counter, its prescaler and any register bus are outside this block. The capture value and the flag are presented directly as outputs for a read path to pick up.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_value_o` is 0, `cap_flag_o` is 0 and `irq_o` is 0.
- R2: With the filter off, a qualifying pin transition that is set up before clock edge k0 stores the `cnt_i` value sampled at edge k0+2. There are two synchroniser stages and one detection stage. The flag is visible after edge k0+2.
- R3: `rise_sel_i` = 1 selects low-to-high transitions and `rise_sel_i` = 0 selects high-to-low transitions. A transition of the other polarity stores nothing and leaves the flag unchanged.
- R4: With `filt_en_i` = 1, the filtered level changes only after four consecutive synchronised samples agree on the new level. A pin pulse lasting 3 clocks causes no capture. A pulse lasting 4 clocks causes one capture.
- R5: With the filter on, the capture happens exactly four clocks later than with the filter off. It stores the `cnt_i` value sampled at edge k0+6.
- R6: Every capture sets `cap_flag_o`. The flag stays set until a one-cycle `flag_clr_i` strobe, and it reads 0 after that strobe.
- R7: When `flag_clr_i` and a capture fall on the same clock edge, the capture wins and the flag stays 1.
- R8: `irq_o` is 1 exactly when `cap_flag_o` is 1 and `irq_en_i` is 1.
- R9: Changing `rise_sel_i` while the pin is steady causes no capture.
- R10: While `top_lock_i` is 1, qualifying transitions neither change `cap_value_o` nor set the flag.
- R11: A later capture overwrites the register with the newer counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value to timestamp with |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| filt_en_i | input | 1 | 1 = route the pin through the four-sample filter |
| rise_sel_i | input | 1 | 1 = rising transition captures, 0 = falling |
| top_lock_i | input | 1 | 1 = capture register in use as counter top; block captures |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle strobe that clears the capture flag |
| cap_value_o | output | CNT_W | Captured counter value (read port) |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The scoreboard predicts the exact capture cycle and counter value for both pin paths. A design that got the filter latency wrong by one clock, or dropped a synchroniser stage, would store a neighbouring counter value. Pulses of three and four clocks probe the filter threshold; an off-by-one there would either pass a glitch or swallow a valid pulse. A clear strobe placed on the capture edge itself catches a design in which the clear beats the new event. Toggling the edge select on a quiet pin catches a detector that compares the pin against the polarity instead of against its own previous level.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int CAP_W_DEF   = 16;
  localparam int SYNC_N_DEF  = 2;
  localparam int FILT_N_DEF  = 4;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = icap_pkg::SYNC_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = icap_pkg::FILT_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,
  output logic filt_o
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist_q, hist_d;
  logic          filt_q, filt_d;
  logic          all_hi, all_lo;

  always_comb begin
    all_hi = &{samp_i, hist_q};
    all_lo = ~|{samp_i, hist_q};
    if (all_hi)      filt_d = 1'b1;
    else if (all_lo) filt_d = 1'b0;
    else             filt_d = filt_q;
    if (HW > 1) hist_d = {hist_q[HW-2:0], samp_i};
    else        hist_d = HW'(samp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(samp_i) == filt_q && $past(hist_q) == {HW{filt_q}})); // R4
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic      prev_q;
  logic      rise, fall;
  edge_pol_e pol;

  always_comb begin
    pol   = edge_pol_e'(rise_sel_i);
    rise  = lvl_i & ~prev_q;
    fall  = ~lvl_i & prev_q;
    evt_o = (pol == POL_RISE) ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (lvl_i == rise_sel_i)); // R3
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rise_sel_i) && $stable(lvl_i)) |-> !evt_o); // R9
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int CNT_W       = icap_pkg::CAP_W_DEF,
  parameter int SYNC_STAGES = icap_pkg::SYNC_N_DEF,
  parameter int FILT_LEN    = icap_pkg::FILT_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_pin_i,
  input  logic             filt_en_i,
  input  logic             rise_sel_i,
  input  logic             top_lock_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  localparam int NSRC = 2;

  logic             pin_s;
  logic             pin_f;
  logic [NSRC-1:0]  src_lvl;
  logic [NSRC-1:0]  src_evt;
  logic             cap_evt;
  logic             cap_en;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, flag_d;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cap_pin_i),
    .q_o   (pin_s)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp_i (pin_s),
    .filt_o (pin_f)
  );

  assign src_lvl = {pin_f, pin_s};

  for (genvar g = 0; g < NSRC; g++) begin : g_det
    icap_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (src_lvl[g]),
      .rise_sel_i (rise_sel_i),
      .evt_o      (src_evt[g])
    );
  end

  always_comb begin
    cap_evt = (filt_en_i ? src_evt[1] : src_evt[0]) & ~top_lock_i;
    cap_en  = cap_evt;
    if (cap_evt)         flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cap_value_o = cap_q;
  assign cap_flag_o  = flag_q;
  assign irq_o       = flag_q & irq_en_i;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag_o); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_evt) |=> !cap_flag_o); // R6
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && cap_evt) |=> cap_flag_o); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    top_lock_i |=> $stable(cap_value_o)); // R10
  AST_CAP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_value_o == $past(cnt_i))); // R11
endmodule

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_i;
  logic        cap_pin_i, filt_en_i, rise_sel_i, top_lock_i, irq_en_i, flag_clr_i;
  logic [15:0] cap_value_o;
  logic        cap_flag_o, irq_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  int          exp_cyc[$];
  logic [15:0] exp_val[$];
  string       exp_tag[$];
  logic [15:0] last_val = 16'h0;
  logic        flag_prev = 1'b0;
  logic [15:0] val_prev = 16'h0;

  icap_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cap_pin_i(cap_pin_i),
    .filt_en_i(filt_en_i), .rise_sel_i(rise_sel_i), .top_lock_i(top_lock_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .cap_value_o(cap_value_o), .cap_flag_o(cap_flag_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] fv(int n);
    return 16'(n * 7 + 100);
  endfunction

  always @(negedge clk) cnt_i = fv(cyc);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: changes the pin and, if a capture is due, pushes the expected item.
  task automatic drive_pin(logic v, bit expect_cap, string tag);
    int lat;
    @(negedge clk);
    cap_pin_i = v;
    if (expect_cap) begin
      lat = filt_en_i ? 7 : 3;
      exp_cyc.push_back(cyc + lat);
      exp_val.push_back(fv(cyc + lat - 1));
      exp_tag.push_back(tag);
      last_val = fv(cyc + lat - 1);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever the design reports a capture.
  always @(negedge clk) begin
    if (rst_n && started) begin
      if ((cap_flag_o && !flag_prev) || (cap_value_o != val_prev)) begin
        if (exp_cyc.size() == 0) begin
          chk("R3 unexpected capture", {16'h0, cap_value_o}, {16'h0, val_prev});
        end else begin
          automatic int          ec = exp_cyc.pop_front();
          automatic logic [15:0] ev = exp_val.pop_front();
          automatic string       et = exp_tag.pop_front();
          chk({et, " capture cycle"}, cyc, ec);
          chk({et, " capture value"}, {16'h0, cap_value_o}, {16'h0, ev});
        end
      end
      flag_prev = cap_flag_o;
      val_prev  = cap_value_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cap_pin_i = 1'b0; filt_en_i = 1'b0; rise_sel_i = 1'b1;
    top_lock_i = 1'b0; irq_en_i = 1'b1; flag_clr_i = 1'b0; cnt_i = 16'h0;
    idle(5);
    rst_n = 1'b1;
    idle(1);
    chk("R1 value", {16'h0, cap_value_o}, 32'h0);
    chk("R1 flag", {31'h0, cap_flag_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    started = 1'b1;

    // Rising capture, unfiltered path (R2), flag hold (R6), irq gating (R8)
    drive_pin(1'b1, 1'b1, "R2");
    idle(6);
    chk("R6 flag set", {31'h0, cap_flag_o}, 32'h1);
    idle(20);
    chk("R6 flag held", {31'h0, cap_flag_o}, 32'h1);
    chk("R8 irq on", {31'h0, irq_o}, 32'h1);
    irq_en_i = 1'b0;
    idle(1);
    chk("R8 irq masked", {31'h0, irq_o}, 32'h0);
    irq_en_i = 1'b1;
    clear_flag();
    chk("R6 flag cleared", {31'h0, cap_flag_o}, 32'h0);
    chk("R8 irq after clear", {31'h0, irq_o}, 32'h0);

    // Opposite polarity ignored (R3)
    drive_pin(1'b0, 1'b0, "R3");
    idle(6);
    chk("R3 falling ignored", {31'h0, cap_flag_o}, 32'h0);
    rise_sel_i = 1'b0;
    drive_pin(1'b1, 1'b0, "R3");
    idle(6);
    chk("R3 rising ignored", {31'h0, cap_flag_o}, 32'h0);
    drive_pin(1'b0, 1'b1, "R3");
    idle(6);
    chk("R3 falling capture flag", {31'h0, cap_flag_o}, 32'h1);
    clear_flag();

    // Edge select toggled on a quiet pin (R9)
    for (int i = 0; i < 4; i++) begin
      rise_sel_i = ~rise_sel_i;
      idle(2);
    end
    chk("R9 no flag", {31'h0, cap_flag_o}, 32'h0);
    chk("R9 value kept", {16'h0, cap_value_o}, {16'h0, last_val});
    rise_sel_i = 1'b1;

    // Filtered path: latency (R5) and pulse threshold (R4)
    filt_en_i = 1'b1;
    idle(8);
    drive_pin(1'b1, 1'b1, "R5");
    idle(10);
    chk("R5 flag", {31'h0, cap_flag_o}, 32'h1);
    clear_flag();
    drive_pin(1'b0, 1'b0, "R4");
    idle(10);
    drive_pin(1'b1, 1'b0, "R4");
    idle(2);
    drive_pin(1'b0, 1'b0, "R4");
    idle(10);
    chk("R4 3-clock pulse rejected", {31'h0, cap_flag_o}, 32'h0);
    drive_pin(1'b1, 1'b1, "R4");
    idle(3);
    drive_pin(1'b0, 1'b0, "R4");
    idle(12);
    chk("R4 4-clock pulse passed", {31'h0, cap_flag_o}, 32'h1);
    clear_flag();
    filt_en_i = 1'b0;
    idle(4);

    // Overwrite (R11) and clear coinciding with capture (R7)
    drive_pin(1'b1, 1'b1, "R11");
    idle(6);
    drive_pin(1'b0, 1'b0, "R11");
    idle(6);
    drive_pin(1'b1, 1'b1, "R7");
    idle(2);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R7 capture beats clear", {31'h0, cap_flag_o}, 32'h1);
    idle(3);
    chk("R7 flag still set", {31'h0, cap_flag_o}, 32'h1);
    clear_flag();

    // Lock suppresses capture (R10)
    drive_pin(1'b0, 1'b0, "R10");
    idle(6);
    top_lock_i = 1'b1;
    drive_pin(1'b1, 1'b0, "R10");
    idle(6);
    chk("R10 flag", {31'h0, cap_flag_o}, 32'h0);
    chk("R10 value", {16'h0, cap_value_o}, {16'h0, last_val});
    top_lock_i = 1'b0;
    idle(10);

    chk("R2 scoreboard drained", exp_cyc.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule